// File: doc/BRIEF.md
# Scanline Playfield Bit Serializer

This block turns three small pattern registers into a one-bit background signal for a raster video line. The registers hold 4, 8 and 8 bits, 20 playfield bits in all, and each bit is stretched over four color clocks. The line has 228 color clocks. The first 68 are horizontal blank, where the output is held low. The remaining 160 clocks show the 20-bit pattern twice: once for the left half and once for the right half. A control bit chooses whether the right half repeats the left in the same order or mirrors it in reverse order.

The registers are read live while the line is drawn. Nothing is latched once per line. A processor that rewrites a register after its left-half segment has been shown, and before its right-half segment starts, changes only the right half of that line. This is how an asymmetric playfield is built. A change of the repeat/mirror control takes effect only at the next four-clock bit boundary, so no pixel is ever narrower than one bit.

Top module: `pf_line_serializer`

## Requirements
- R1: While reset is active and after it is released, `pf_out` is 0. All pattern registers and the mirror control reset to 0.
- R2: A `line_start` pulse sampled at a clock edge sets the horizontal position to 0. The pixel for position h appears on `pf_out` h+1 clock edges after that edge.
- R3: For positions 0 to 67 (horizontal blank), `pf_out` is 0.
- R4: Each playfield bit lasts 4 clocks. The left half (positions 68 to 147) shows bits in this order: the pattern-0 register bits 0..3 (taken from write data bits 4..7), then pattern-1 bits 7 down to 0, then pattern-2 bits 0 up to 7.
- R5: When the mirror control is 0, positions 148 to 227 repeat the left-half order.
- R6: When the mirror control is 1, positions 148 to 227 show the 20 left-half bits in reverse order, ending with write data bit 4 of pattern 0.
- R7: Write address encoding on `wr_sel`: 0 = pattern 0 (from `wr_data[7:4]`), 1 = pattern 1, 2 = pattern 2, 3 = control (`wr_data[0]` = 1 selects mirror). A data write registered at edge m is used for every pixel from position m onward on that line. Earlier pixels keep the old value.
- R8: A control write registered at edge m affects pixels only from the first bit start at a position of m+1 or later. Pixels in the current bit keep the old mode.
- R9: Without a new `line_start`, the position wraps from 227 back to 0, and the next line is drawn identically.
- R10: Bits 3..0 of a pattern-0 write have no effect on `pf_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Color clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Horizontal sync pulse; restarts the line |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (see R7) |
| wr_data | input | 8 | Write data |
| pf_out | output | 1 | Playfield pixel |

## Verification
The pixel for position h is due h+1 edges after the edge that samples `line_start`. A data write registered at edge m changes the output from position m onward. A mode write changes it only from the first bit start after m. The driver pushes the whole expected line into the scoreboard queue when it raises `line_start`. Two leading don't-care entries cover the edge that samples the pulse and the stale pixel computed at that edge. The monitor then pops exactly one entry per falling edge. The mid-line cases are placed at the edge of a window: a pattern-2 rewrite in mirror mode lands on the very first position of its right copy, and a mode switch lands two clocks into a bit. With that placement a one-cycle slip shows up as a mismatch.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int unsigned PF0_W     = 4;
    localparam int unsigned PF1_W     = 8;
    localparam int unsigned PF2_W     = 8;
    localparam int unsigned HALF_BITS = PF0_W + PF1_W + PF2_W;

    typedef enum logic [1:0] {
        SEL_PF0  = 2'd0,
        SEL_PF1  = 2'd1,
        SEL_PF2  = 2'd2,
        SEL_CTRL = 2'd3
    } pf_sel_e;

    // Left-half bit sequence; element 0 is shown first.
    function automatic logic [HALF_BITS-1:0] left_seq(
        input logic [PF0_W-1:0] a,
        input logic [PF1_W-1:0] b,
        input logic [PF2_W-1:0] c
    );
        logic [HALF_BITS-1:0] s;
        for (int i = 0; i < int'(PF0_W); i++) s[i] = a[i];
        for (int i = 0; i < int'(PF1_W); i++) s[PF0_W + i] = b[PF1_W - 1 - i];
        for (int i = 0; i < int'(PF2_W); i++) s[PF0_W + PF1_W + i] = c[i];
        return s;
    endfunction
endpackage

// File: rtl/pf_hcount.sv
module pf_hcount #(
    parameter int unsigned LINE_CLKS   = 228,
    parameter int unsigned HBLANK_CLKS = 68,
    parameter int unsigned BIT_CLKS    = 4,
    localparam int unsigned HPOS_W     = $clog2(LINE_CLKS),
    localparam int unsigned BIDX_W     = $clog2(2 * pf_pkg::HALF_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    output logic [HPOS_W-1:0] hpos_o,
    output logic              vis_o,
    output logic [BIDX_W-1:0] bidx_o,
    output logic              stage_o
);
    localparam logic [HPOS_W-1:0] LAST = HPOS_W'(LINE_CLKS - 1);
    localparam logic [HPOS_W-1:0] HB   = HPOS_W'(HBLANK_CLKS);

    typedef struct packed {
        logic [HPOS_W-1:0] hpos;
    } cnt_t;

    cnt_t cur_q, nxt_d;
    logic [HPOS_W-1:0] xoff;

    always_comb begin
        nxt_d = cur_q;
        if (line_start)            nxt_d.hpos = '0;
        else if (cur_q.hpos == LAST) nxt_d.hpos = '0;
        else                       nxt_d.hpos = cur_q.hpos + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        vis_o   = (cur_q.hpos >= HB);
        xoff    = cur_q.hpos - HB;
        bidx_o  = vis_o ? BIDX_W'(32'(xoff) / BIT_CLKS) : '0;
        stage_o = !vis_o || ((32'(xoff) % BIT_CLKS) == BIT_CLKS - 1);
        hpos_o  = cur_q.hpos;
    end

    assert_line_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (cur_q.hpos == '0));

    assert_line_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && cur_q.hpos == LAST) |=> (cur_q.hpos == '0));
endmodule

// File: rtl/pf_regs.sv
module pf_regs #(
    parameter int unsigned DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     stage,
    output logic [pf_pkg::PF0_W-1:0] pf0_o,
    output logic [pf_pkg::PF1_W-1:0] pf1_o,
    output logic [pf_pkg::PF2_W-1:0] pf2_o,
    output logic                     mirror_o
);
    import pf_pkg::*;

    typedef struct packed {
        logic [PF0_W-1:0] pf0;
        logic [PF1_W-1:0] pf1;
        logic [PF2_W-1:0] pf2;
        logic             mir_req;
        logic             mir_use;
    } reg_t;

    reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr_en) begin
            case (pf_sel_e'(wr_sel))
                SEL_PF0:  nxt_d.pf0     = wr_data[DATA_W-1 -: PF0_W];
                SEL_PF1:  nxt_d.pf1     = wr_data[PF1_W-1:0];
                SEL_PF2:  nxt_d.pf2     = wr_data[PF2_W-1:0];
                SEL_CTRL: nxt_d.mir_req = wr_data[0];
                default:  ;
            endcase
        end
        // mode only moves at a bit end or during blank
        if (stage) nxt_d.mir_use = cur_q.mir_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pf0_o    = cur_q.pf0;
    assign pf1_o    = cur_q.pf1;
    assign pf2_o    = cur_q.pf2;
    assign mirror_o = cur_q.mir_use;

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stage |=> $stable(cur_q.mir_use));

    assert_pf1_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (cur_q.pf1 == $past(wr_data[PF1_W-1:0])));
endmodule

// File: rtl/pf_pixel.sv
module pf_pixel #(
    localparam int unsigned BIDX_W = $clog2(2 * pf_pkg::HALF_BITS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vis,
    input  logic [BIDX_W-1:0]        bidx,
    input  logic                     mirror,
    input  logic [pf_pkg::PF0_W-1:0] pf0,
    input  logic [pf_pkg::PF1_W-1:0] pf1,
    input  logic [pf_pkg::PF2_W-1:0] pf2,
    output logic                     pix_o
);
    import pf_pkg::*;

    typedef struct packed {
        logic pix;
    } pix_t;

    pix_t cur_q, nxt_d;
    logic [HALF_BITS-1:0] seq;
    int unsigned b, idx;

    always_comb begin
        nxt_d = cur_q;
        seq   = left_seq(pf0, pf1, pf2);
        b     = 32'(bidx);
        if (b < HALF_BITS)  idx = b;
        else if (mirror)    idx = 2 * HALF_BITS - 1 - b;
        else                idx = b - HALF_BITS;
        nxt_d.pix = vis && (idx < HALF_BITS) && seq[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pix_o = cur_q.pix;
endmodule

// File: rtl/pf_line_serializer.sv
module pf_line_serializer #(
    parameter int unsigned LINE_CLKS   = 228,
    parameter int unsigned HBLANK_CLKS = 68,
    parameter int unsigned BIT_CLKS    = 4,
    parameter int unsigned DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pf_out
);
    import pf_pkg::*;

    localparam int unsigned HPOS_W = $clog2(LINE_CLKS);
    localparam int unsigned BIDX_W = $clog2(2 * HALF_BITS);

    logic [HPOS_W-1:0] hpos;
    logic              vis, stage, mirror;
    logic [BIDX_W-1:0] bidx;
    logic [PF0_W-1:0]  pf0;
    logic [PF1_W-1:0]  pf1;
    logic [PF2_W-1:0]  pf2;

    pf_hcount #(
        .LINE_CLKS  (LINE_CLKS),
        .HBLANK_CLKS(HBLANK_CLKS),
        .BIT_CLKS   (BIT_CLKS)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .hpos_o    (hpos),
        .vis_o     (vis),
        .bidx_o    (bidx),
        .stage_o   (stage)
    );

    pf_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .stage   (stage),
        .pf0_o   (pf0),
        .pf1_o   (pf1),
        .pf2_o   (pf2),
        .mirror_o(mirror)
    );

    pf_pixel u_pix (
        .clk   (clk),
        .rst_n (rst_n),
        .vis   (vis),
        .bidx  (bidx),
        .mirror(mirror),
        .pf0   (pf0),
        .pf1   (pf1),
        .pf2   (pf2),
        .pix_o (pf_out)
    );

    assert_blank_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos < HPOS_W'(HBLANK_CLKS)) |=> !pf_out);
endmodule

// File: tb/sim_pf_line_serializer.sv
`timescale 1ns/1ps
module sim_pf_line_serializer;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       line_start = 0;
    logic       wr_en = 0;
    logic [1:0] wr_sel = 0;
    logic [7:0] wr_data = 0;
    logic       pf_out;

    int checks = 0;
    int failures = 0;
    string cur_tag = "";

    typedef struct {
        int val;
        int pos;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    pf_line_serializer u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pf_out(pf_out)
    );

    function automatic int ref_pix(int h, logic [7:0] p0, logic [7:0] p1,
                                   logic [7:0] p2, bit mir);
        int b, i;
        if (h < 68) return 0;
        b = (h - 68) / 4;
        if (b < 20)   i = b;
        else if (mir) i = 39 - b;
        else          i = b - 20;
        if (i < 4)       return int'(p0[4 + i]);
        else if (i < 12) return int'(p1[11 - i]);
        else             return int'(p2[i - 12]);
    endfunction

    task automatic check(bit ok, string req, int act, int exp, int pos);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s pos=%0d actual=%0d expected=%0d", req, pos, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.val >= 0)
                check(int'(pf_out) == e.val, cur_tag, int'(pf_out), e.val, e.pos);
        end
    end

    task automatic write_reg(logic [1:0] sel, logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    // wsel < 0: no mid-line write; m = edge count after the line_start edge
    task automatic run_line(string tag, logic [7:0] a0, logic [7:0] a1, logic [7:0] a2,
                            bit mir, int wsel, logic [7:0] wd, int m, int nlines);
        logic [7:0] n0, n1, n2;
        bit nmir;
        write_reg(2'd0, a0);
        write_reg(2'd1, a1);
        write_reg(2'd2, a2);
        write_reg(2'd3, {7'd0, mir});
        n0 = a0; n1 = a1; n2 = a2; nmir = mir;
        case (wsel)
            0: n0 = wd;
            1: n1 = wd;
            2: n2 = wd;
            3: nmir = wd[0];
            default: ;
        endcase
        cur_tag = tag;
        @(posedge clk); #1;
        line_start = 1;
        exp_q.push_back('{-1, -1});
        exp_q.push_back('{-1, -1});
        for (int g = 0; g < 228 * nlines; g++) begin
            int h, s;
            bit dnew, mnew;
            h = g % 228;
            s = (g - h) + 68 + 4 * ((h >= 68) ? (h - 68) / 4 : 0);
            dnew = (wsel >= 0) && (g >= m);
            mnew = (wsel == 3) && (s >= m + 1);
            exp_q.push_back('{ref_pix(h, dnew ? n0 : a0, dnew ? n1 : a1,
                                      dnew ? n2 : a2, mnew ? nmir : mir), h});
        end
        @(posedge clk); #1;
        line_start = 0;
        if (wsel >= 0) begin
            repeat (m - 1) @(posedge clk);
            #1;
            wr_en = 1; wr_sel = 2'(wsel); wr_data = wd;
            @(posedge clk); #1;
            wr_en = 0;
        end
        wait (exp_q.size() == 0);
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(pf_out == 1'b0, "R1 in reset", int'(pf_out), 0, -1);
        @(posedge clk); #1;
        rst_n = 1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(pf_out == 1'b0, "R1 after reset", int'(pf_out), 0, k);
        end
        // R1 registers zero: a full line with no writes stays dark
        cur_tag = "R1 zero regs";
        @(posedge clk); #1; line_start = 1;
        exp_q.push_back('{-1, -1}); exp_q.push_back('{-1, -1});
        for (int h = 0; h < 228; h++) exp_q.push_back('{0, h});
        @(posedge clk); #1; line_start = 0;
        wait (exp_q.size() == 0);
        @(posedge clk); #1;

        // R2 R3 R4 R5: repeat mode
        run_line("R4 R5 repeat", 8'hA0, 8'h5C, 8'h93, 1'b0, -1, 8'h00, 0, 1);
        // R6: mirror mode
        run_line("R6 mirror", 8'hA0, 8'h5C, 8'h93, 1'b1, -1, 8'h00, 0, 1);
        // R10: low nibble of pattern 0 ignored
        run_line("R10 low nibble", 8'h0F, 8'h00, 8'h00, 1'b0, -1, 8'h00, 0, 1);
        // R7: pattern 0 rewritten between its left and right segments
        run_line("R7 mid-line pf0", 8'h30, 8'hFF, 8'h01, 1'b0, 0, 8'hC0, 100, 1);
        // R7: mirror mode, pattern 2 rewritten on the first right-copy position
        run_line("R7 pf2 boundary", 8'h00, 8'h00, 8'h0F, 1'b1, 2, 8'hF0, 148, 1);
        // R8: repeat -> mirror two clocks into a bit
        run_line("R8 mode switch", 8'h10, 8'h00, 8'h40, 1'b0, 3, 8'h01, 150, 1);
        // R9: free-running wrap over two lines
        run_line("R9 wrap", 8'h50, 8'h3C, 8'hA5, 1'b1, -1, 8'h00, 0, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule